// File: doc/BRIEF.md
# Fast Ethernet Receive PCS Decoder

This block converts the symbol stream arriving from a 100 Mb/s copper or fibre PMD into the nibble stream of a MAC receive interface. Every clock it takes one 5-bit code group. The groups are not aligned to symbol boundaries. The block removes the stream cipher, finds the true code-group boundaries from the start-of-stream delimiter, and decodes each group into a 4-bit nibble. The results appear on `rxd`, `rxdv` and `rxer`.

The input stream carries one symbol per clock and the output carries at most one nibble per clock. Neither side can pause the other. The output has no ready signal, so the consumer has to accept every nibble on the clock where `rxdv` is high. `sig_det` reports a live line. A built-in timer turns it into a link-up condition, and a lost link aborts any frame in progress.

Top module: `rxpcs_decoder`

## Requirements
- R1: Frames are recognised only after `sig_det` has been high for LINK_CYCLES (default 8250) consecutive clocks. A low `sig_det` on any clock restarts this count.
- R2: When `sig_det` is low on a clock edge, `rxdv`, `rxd` and `rxer` are all 0 after that edge, even in the middle of a frame.
- R3: The descrambler regains lock by reloading its key register once LOCK_IDLES (default 13) consecutive symbols agree with an idle stream. A start delimiter that arrives before lock is ignored unless the cipher is bypassed.
- R4: The descrambled bit equals the received bit XOR the key bit. The key sequence follows k[n] = k[n-11] XOR k[n-9]. When `cipher_off` is 1, the received bits pass through unchanged.
- R5: Bits are taken serially, `sym_in[4]` first. Symbol alignment is found at any of the five bit offsets by searching for J (11000) followed by K (10001) after idle (11111) groups.
- R6: The J,K pair is delivered as the nibbles 5,5. A T (01101) immediately followed by R (00111) ends the frame and is delivered as the nibbles 0,0.
- R7: Data groups are decoded with the standard 4B/5B table (0=11110, 1=01001, ... F=11101). Any other group inside a frame, including H (00100), sets `rxer` high for exactly that nibble.
- R8: `rxdv` is high without a gap from the first 5 nibble through the last nibble of a frame, and it is low on the clock after the last nibble.
- R9: Two consecutive idle groups inside a frame before any T/R end it. The nibbles delivered are 5,5 and the data, with no trailing 0,0.
- R10: `rxd` is 0 on every clock where `rxdv` is 0.
- R11: A J not followed by K does not start a frame. Searching continues, and a later proper J,K is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 5 | Received code-group bits, bit 4 earliest |
| cipher_off | input | 1 | 1 bypasses the descrambler |
| sig_det | input | 1 | Signal detect from the PMD |
| rxd | output | 4 | Decoded nibble |
| rxdv | output | 1 | Nibble on `rxd` belongs to a frame |
| rxer | output | 1 | Current nibble came from an invalid code group |

## Verification
Frames are sent at all five bit offsets, with the cipher both on and off. This separates alignment faults from key-sequence faults. A frame ended early by idles is compared against a normal T/R ending, and a corrupted data group is compared against clean data, so the end-of-frame handling and the error flag can each be isolated. Directed runs cover the cases where the link timer has not expired, where signal detect drops in the middle of a frame, and where the cipher is not yet locked. Each of these must produce no `rxdv` at all. A false J before the real delimiter checks that searching resumes.

// File: rtl/rxpcs_pkg.sv
package rxpcs_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int KEY_W = 11;
  localparam int TAP_FAR = KEY_W - 1;
  localparam int TAP_NEAR = 8;

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R = 5'b00111;
  localparam logic [NIB_W-1:0] NIB_SSD = 4'h5;
  localparam logic [NIB_W-1:0] NIB_ESD = 4'h0;

  typedef enum logic [1:0] {FR_HUNT, FR_SECOND, FR_BODY, FR_TAIL} frame_st_t;

  typedef struct packed {
    logic ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  typedef struct packed {
    logic [SYM_W-1:0] bits;
    logic [KEY_W-1:0] st;
  } key_step_t;

  // Advance the key generator by one symbol; bit SYM_W-1 is produced first.
  function automatic key_step_t key_advance(input logic [KEY_W-1:0] s);
    key_step_t r;
    logic [KEY_W-1:0] t;
    logic b;
    t = s;
    r.bits = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      b = t[TAP_FAR] ^ t[TAP_NEAR];
      r.bits[i] = b;
      t = {t[KEY_W-2:0], b};
    end
    r.st = t;
    return r;
  endfunction

  function automatic dec_t code_to_nib(input logic [SYM_W-1:0] s);
    dec_t d;
    d.ok = 1'b1;
    case (s)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.ok = 1'b0;
        d.nib = '0;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rxpcs_link_timer.sv
module rxpcs_link_timer #(
  parameter int LINK_CYCLES = 8250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det,
  output logic link_ok
);
  localparam int CW = $clog2(LINK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LINK_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!sig_det) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign link_ok = sig_det && (cnt == CNT_MAX);
endmodule

// File: rtl/rxpcs_descrambler.sv
module rxpcs_descrambler
  import rxpcs_pkg::*;
#(
  parameter int LOCK_IDLES = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_ok,
  input  logic             bypass,
  input  logic [SYM_W-1:0] sym_raw,
  output logic [SYM_W-1:0] sym_plain,
  output logic             ready
);
  localparam int CW = $clog2(LOCK_IDLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_IDLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_IDLES - 1);

  logic [KEY_W-1:0] hist, ks, hist_nxt;
  logic [CW-1:0]    icnt;
  logic             locked, match;
  logic [SYM_W-1:0] nrx;
  key_step_t        ks_step, hs_step;

  // Under an idle stream the complemented line bits are the key itself.
  assign nrx      = ~sym_raw;
  assign hist_nxt = {hist[KEY_W-SYM_W-1:0], nrx};
  assign ks_step  = key_advance(ks);
  assign hs_step  = key_advance(hist);
  assign match    = (hs_step.bits == nrx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      ks     <= '0;
      icnt   <= '0;
      locked <= 1'b0;
    end else begin
      hist <= hist_nxt;
      if (!link_ok) begin
        icnt   <= '0;
        locked <= 1'b0;
        ks     <= ks_step.st;
      end else if (match) begin
        if (icnt != CNT_MAX) icnt <= icnt + 1'b1;
        if (icnt >= CNT_LAST) begin
          ks     <= hist_nxt;
          locked <= 1'b1;
        end else begin
          ks <= ks_step.st;
        end
      end else begin
        icnt <= '0;
        ks   <= ks_step.st;
      end
    end
  end

  assign sym_plain = bypass ? sym_raw : (sym_raw ^ ks_step.bits);
  assign ready     = locked | bypass;
endmodule

// File: rtl/rxpcs_aligner.sv
module rxpcs_aligner
  import rxpcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic             hunt,
  input  logic [SYM_W-1:0] sym_plain,
  output logic             jk_hit,
  output logic [SYM_W-1:0] sym_al
);
  localparam int PAIR_W = 2 * SYM_W;
  localparam int WIN_W = 3 * SYM_W - 1;
  localparam int OFF_W = $clog2(SYM_W + 1);
  localparam logic [PAIR_W-1:0] JK_PAT = {SYM_J, SYM_K};

  logic [SYM_W-2:0]  p1;
  logic [SYM_W-1:0]  p0;
  logic [OFF_W-1:0]  off, hit_off;
  logic              armed, hit;
  logic [WIN_W-1:0]  win;
  logic [PAIR_W-1:0] pair;

  assign win  = {p1, p0, sym_plain};
  assign pair = {p0, sym_plain};

  // Offsets 1..SYM_W put the end of the pattern inside the newest symbol.
  always_comb begin
    hit     = 1'b0;
    hit_off = '0;
    for (int o = SYM_W; o >= 1; o--) begin
      if (win[WIN_W-o -: PAIR_W] == JK_PAT) begin
        hit     = 1'b1;
        hit_off = OFF_W'(o);
      end
    end
  end

  assign jk_hit = hit && hunt && armed && ready;
  assign sym_al = pair[(PAIR_W - 1 - int'(off)) -: SYM_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1    <= '1;
      p0    <= '1;
      off   <= OFF_W'(SYM_W);
      armed <= 1'b0;
    end else begin
      p1 <= p0[SYM_W-2:0];
      p0 <= sym_plain;
      if (jk_hit) off <= hit_off;
      if (!ready || !hunt) armed <= 1'b0;
      else if (pair == '1) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rxpcs_framer.sv
module rxpcs_framer
  import rxpcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_ok,
  input  logic             jk_hit,
  input  logic [SYM_W-1:0] sym_al,
  output logic             hunt,
  output logic [NIB_W-1:0] rxd,
  output logic             rxdv,
  output logic             rxer
);
  frame_st_t        st;
  logic [SYM_W-1:0] q;
  dec_t             qd;

  assign qd   = code_to_nib(q);
  assign hunt = (st == FR_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_HUNT;
      q    <= SYM_IDLE;
      rxd  <= '0;
      rxdv <= 1'b0;
      rxer <= 1'b0;
    end else if (!link_ok) begin
      st   <= FR_HUNT;
      rxd  <= '0;
      rxdv <= 1'b0;
      rxer <= 1'b0;
    end else begin
      case (st)
        FR_HUNT: begin
          rxer <= 1'b0;
          if (jk_hit) begin
            rxdv <= 1'b1;
            rxd  <= NIB_SSD;
            st   <= FR_SECOND;
          end else begin
            rxdv <= 1'b0;
            rxd  <= '0;
          end
        end
        FR_SECOND: begin
          rxd <= NIB_SSD;
          q   <= sym_al;
          st  <= FR_BODY;
        end
        FR_BODY: begin
          if (q == SYM_T && sym_al == SYM_R) begin
            rxd  <= NIB_ESD;
            rxer <= 1'b0;
            st   <= FR_TAIL;
          end else if (q == SYM_IDLE && sym_al == SYM_IDLE) begin
            rxdv <= 1'b0;
            rxd  <= '0;
            rxer <= 1'b0;
            st   <= FR_HUNT;
          end else begin
            rxd  <= qd.nib;
            rxer <= !qd.ok;
            q    <= sym_al;
          end
        end
        default: begin
          rxd  <= NIB_ESD;
          rxer <= 1'b0;
          st   <= FR_HUNT;
        end
      endcase
    end
  end
endmodule

// File: rtl/rxpcs_decoder.sv
module rxpcs_decoder
  import rxpcs_pkg::*;
#(
  parameter int LINK_CYCLES = 8250,
  parameter int LOCK_IDLES = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             cipher_off,
  input  logic             sig_det,
  output logic [NIB_W-1:0] rxd,
  output logic             rxdv,
  output logic             rxer
);
  logic             link_ok, ready, hunt, jk_hit;
  logic [SYM_W-1:0] sym_plain, sym_al;

  rxpcs_link_timer #(.LINK_CYCLES(LINK_CYCLES)) u_link (
    .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .link_ok(link_ok)
  );

  rxpcs_descrambler #(.LOCK_IDLES(LOCK_IDLES)) u_dscr (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .bypass(cipher_off),
    .sym_raw(sym_in), .sym_plain(sym_plain), .ready(ready)
  );

  rxpcs_aligner u_align (
    .clk(clk), .rst_n(rst_n), .ready(ready), .hunt(hunt),
    .sym_plain(sym_plain), .jk_hit(jk_hit), .sym_al(sym_al)
  );

  rxpcs_framer u_frame (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .jk_hit(jk_hit),
    .sym_al(sym_al), .hunt(hunt), .rxd(rxd), .rxdv(rxdv), .rxer(rxer)
  );
endmodule

// File: rtl/rxpcs_decoder_chk.sv
module rxpcs_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sig_det,
  input logic [3:0] rxd,
  input logic       rxdv,
  input logic       rxer
);
  AST_DV_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    rxdv |-> $past(sig_det)); // R1
  AST_LINK_DROP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det |=> !rxdv); // R2
  AST_SSD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxdv) |-> rxd == 4'h5); // R6
  AST_SSD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxdv) && sig_det) |=> (rxdv && rxd == 4'h5)); // R6
  AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rxer |-> rxdv); // R7
  AST_RXD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rxdv |-> rxd == 4'h0); // R10
endmodule

bind rxpcs_decoder rxpcs_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sig_det(sig_det),
  .rxd(rxd), .rxdv(rxdv), .rxer(rxer)
);

// File: tb/rxpcs_decoder_test.sv
module rxpcs_decoder_test;
  localparam logic [4:0] S_I = 5'b11111, S_J = 5'b11000, S_K = 5'b10001;
  localparam logic [4:0] S_T = 5'b01101, S_R = 5'b00111, S_H = 5'b00100;
  localparam int NV = 8;
  // {offset[47:45], bypass[44], kind[43:42], bad[41:38], pad[37:36], len[35:32], data[31:0]}
  // kind: 0 T/R end, 1 two-idle end, 2 H at index bad, 3 false J before frame
  localparam logic [47:0] VEC [NV] = '{
    {3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 4'd8, 32'hFEDCBA98},
    {3'd1, 1'b0, 2'd0, 4'd0, 2'd0, 4'd4, 32'h0000A5C3},
    {3'd2, 1'b1, 2'd0, 4'd0, 2'd0, 4'd6, 32'h0012F0E1},
    {3'd3, 1'b0, 2'd1, 4'd0, 2'd0, 4'd5, 32'h0009A7B6},
    {3'd4, 1'b0, 2'd2, 4'd2, 2'd0, 4'd6, 32'h00445566},
    {3'd0, 1'b1, 2'd2, 4'd0, 2'd0, 4'd3, 32'h00000321},
    {3'd2, 1'b0, 2'd3, 4'd0, 2'd0, 4'd4, 32'h00007E3F},
    {3'd3, 1'b0, 2'd0, 4'd0, 2'd0, 4'd1, 32'h0000000D}
  };

  logic clk = 1'b0, rst_n = 1'b0, cipher_off = 1'b0, sig_det = 1'b1;
  logic [4:0] sym_in = 5'b11111;
  logic [3:0] rxd;
  logic rxdv, rxer;

  int checks = 0, fails = 0, cap_n = 0, rises = 0, zviol = 0;
  logic [3:0] cap_d [64];
  logic cap_e [64];
  logic prev_dv = 1'b0, done = 1'b0;
  logic [10:0] kst = 11'h5A3;
  logic [4:0] sh = '0;
  int nb = 0;

  always #2 clk = ~clk;

  rxpcs_decoder uut (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .cipher_off(cipher_off),
    .sig_det(sig_det), .rxd(rxd), .rxdv(rxdv), .rxer(rxer)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rxdv && cap_n < 64) begin
        cap_d[cap_n] = rxd;
        cap_e[cap_n] = rxer;
        cap_n = cap_n + 1;
      end
      if (rxdv && !prev_dv) rises = rises + 1;
      if (!rxdv && rxd != 4'h0) zviol = zviol + 1;
      prev_dv = rxdv;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  // R4: key k[n] = k[n-11] ^ k[n-9], line bit = plain ^ key unless bypassed
  task automatic send_bit(input logic b);
    logic k;
    k = kst[10] ^ kst[8];
    kst = {kst[9:0], k};
    sh = {sh[3:0], cipher_off ? b : (b ^ k)};
    nb++;
    if (nb == 5) begin
      @(negedge clk);
      sym_in = sh;
      nb = 0;
    end
  endtask

  task automatic send_sym(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) send_bit(s[i]);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) send_sym(S_I);
  endtask

  task automatic short_frame();
    send_sym(S_J); send_sym(S_K);
    send_sym(enc(4'h3)); send_sym(enc(4'hC));
    send_sym(S_T); send_sym(S_R);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rxdv == 1'b0, "R10 reset rxdv", rxdv, 0);
    chk(rxd == 4'h0, "R10 reset rxd", rxd, 0);
    chk(rxer == 1'b0, "R7 reset rxer", rxer, 0);
    rst_n = 1'b1;

    // R1: a frame before the link timer expires is not recognised
    idles(7950);
    short_frame();
    idles(10);
    chk(cap_n == 0, "R1 frame before link up", cap_n, 0);
    idles(400);

    for (int v = 0; v < NV; v++) begin
      logic [47:0] e;
      int off, kind, bad, len, nexp, mism, emis, first_a, first_e;
      logic [3:0] xn [20];
      logic xe [20];
      e = VEC[v];
      off = int'(e[47:45]); kind = int'(e[43:42]); bad = int'(e[41:38]); len = int'(e[35:32]);
      cipher_off = e[44];
      cap_n = 0; rises = 0;
      for (int i = 0; i < off; i++) send_bit(1'b1);
      idles(30);
      if (kind == 3) begin
        send_sym(S_J); send_sym(S_I); idles(20);
      end
      send_sym(S_J); send_sym(S_K);
      for (int i = 0; i < len; i++) begin
        if (kind == 2 && i == bad) send_sym(S_H);
        else send_sym(enc(e[4*i +: 4]));
      end
      if (kind == 1) begin
        send_sym(S_I); send_sym(S_I);
      end else begin
        send_sym(S_T); send_sym(S_R);
      end
      idles(20);
      nexp = 0;
      xn[nexp] = 4'h5; xe[nexp] = 1'b0; nexp++;
      xn[nexp] = 4'h5; xe[nexp] = 1'b0; nexp++;
      for (int i = 0; i < len; i++) begin
        xn[nexp] = e[4*i +: 4];
        xe[nexp] = (kind == 2 && i == bad);
        nexp++;
      end
      if (kind != 1) begin
        xn[nexp] = 4'h0; xe[nexp] = 1'b0; nexp++;
        xn[nexp] = 4'h0; xe[nexp] = 1'b0; nexp++;
      end
      chk(cap_n == nexp, kind == 1 ? "R9 R8 nibble count" : "R6 R8 nibble count", cap_n, nexp);
      chk(rises == 1, kind == 3 ? "R11 R8 one frame" : "R8 one frame", rises, 1);
      mism = 0; emis = 0; first_a = 0; first_e = 0;
      for (int i = 0; i < nexp && i < cap_n; i++) begin
        if (!xe[i] && cap_d[i] != xn[i]) begin
          if (mism == 0) begin first_a = int'(cap_d[i]); first_e = int'(xn[i]); end
          mism++;
        end
        if (cap_e[i] != xe[i]) emis++;
      end
      chk(mism == 0, "R4 R5 R6 payload", first_a, first_e);
      chk(emis == 0, "R7 rxer per nibble", emis, 0);
    end
    cipher_off = 1'b0;

    // R2: signal detect drop in the middle of a frame
    idles(30);
    send_sym(S_J); send_sym(S_K);
    send_sym(enc(4'h1)); send_sym(enc(4'h2)); send_sym(enc(4'h3));
    chk(rxdv == 1'b1, "R2 frame active before drop", rxdv, 1);
    sig_det = 1'b0;
    send_sym(enc(4'h4));
    chk(rxdv == 1'b0, "R2 rxdv after drop", rxdv, 0);
    sig_det = 1'b1;
    send_sym(enc(4'h5));
    cap_n = 0;
    // R1: the count restarts after the drop
    idles(6);
    short_frame();
    idles(10);
    chk(cap_n == 0, "R1 restart after drop", cap_n, 0);

    // R3: link up over non-idle traffic; no lock yet, so the frame is ignored
    for (int i = 0; i < 8300; i++) send_sym(enc(4'h0));
    cap_n = 0;
    idles(5);
    short_frame();
    chk(cap_n == 0, "R3 no frame before lock", cap_n, 0);
    idles(30);
    cap_n = 0; rises = 0;
    short_frame();
    idles(10);
    chk(cap_n == 6 && rises == 1, "R3 frame after lock", cap_n, 6);

    chk(zviol == 0, "R10 rxd zero while idle", zviol, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule